// File: doc/BRIEF.md
# Rename Buffer Write-Back Scheduler

This block sits between instruction completion and the architectural register file. Each cycle, completion hands it a set of results that have just retired. Each result carries the rename entry that holds it, the architectural destination register and the data. An instruction that updates two registers simply uses two input slots. The scheduler queues these results and writes them to the register file through exactly two write ports, over as many later cycles as needed. Completion therefore never stalls on register-file ports.

Pending results drain oldest-first, so writes to the same architectural register land in program order. If both ports would write the same register in one cycle, only the younger write is strobed. Every rename entry that leaves the queue is handed back to the rename allocator one cycle after its write cycle. The count of waiting results and a full flag are reported so that upstream allocation can apply back-pressure.

Top module: `rb_writeback_sched`

## Requirements
- R1: A synchronous active-high reset empties the queue. In the cycle after a reset edge, `pend_count` is 0, `pend_full` is 0, `wr_en` is 2'b00 and `rel_valid` is 2'b00, even if results were pending before the reset.
- R2: At each clock edge, the valid input slots are accepted in slot order, with lower slot indices treated as older. Invalid slots leave no gap. A result accepted at edge N is visible on a write port in the cycle that follows edge N.
- R3: Up to two pending results are presented per cycle, and each one is written at the next edge. Port 0 always carries the oldest pending result and port 1 the next oldest. Port 1 is idle when fewer than two results are pending.
- R4: When both ports carry the same destination register, `wr_en[0]` is held low and `wr_en[1]` is high, so the younger value is the one written.
- R5: Every result that leaves the queue is reported in the cycle after its write cycle. Release lane k (`rel_valid[k]`, `rel_tag[k]`) corresponds to port k. This includes a result whose write strobe was suppressed under R4.
- R6: `pend_count` equals the number of results waiting, and `pend_full` is high exactly when that number equals DEPTH.
- R7: Free space at an edge is DEPTH minus `pend_count` plus the number of results leaving at that edge. Valid slots beyond that space are dropped, and the youngest slots are dropped first. `pend_count` never exceeds DEPTH.
- R8: Acceptance of new results never waits on draining. In a single edge, up to SLOTS results can enter while two leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | SLOTS | Completed-result slot valid; bit 0 is the oldest slot |
| cmp_tag | input | SLOTS x 4 | Rename entry holding each result |
| cmp_reg | input | SLOTS x 5 | Architectural destination register of each result |
| cmp_data | input | SLOTS x 32 | Result value |
| wr_en | output | 2 | Register-file write strobes; port 0 is older |
| wr_reg | output | 2 x 5 | Destination register per write port |
| wr_data | output | 2 x 32 | Write data per port |
| rel_valid | output | 2 | Rename entry release, one cycle after its write cycle |
| rel_tag | output | 2 x 4 | Released rename entry per lane |
| pend_count | output | clog2(DEPTH+1) | Results waiting for write-back |
| pend_full | output | 1 | All DEPTH queue places occupied |

## Verification
The bench pushes sparse slot masks, so a design that packed slots by their index rather than by rank would leave holes or write registers out of order. It also pushes two results for one register in a single cycle: a design that strobed both ports, or kept the older value, would leave the wrong data in the register file. A second test overfills the queue while it drains, then checks that the queue reaches full and drops only the youngest slots. A design that ignored the same-edge drain when computing free space would never reach full and would drop the wrong slots. The release lanes are checked for both entries after a same-register pair, so a design that released only strobed writes would lose a rename entry.

// File: rtl/rbwb_pkg.sv
package rbwb_pkg;

    localparam int WB_TAG_W  = 4;
    localparam int WB_REG_W  = 5;
    localparam int WB_DATA_W = 32;
    localparam int WB_PORTS  = 2;

    typedef logic [WB_TAG_W-1:0]  tag_t;
    typedef logic [WB_REG_W-1:0]  areg_t;
    typedef logic [WB_DATA_W-1:0] data_t;

    typedef struct packed {
        tag_t  tag;
        areg_t rd;
        data_t data;
    } wb_item_t;

    function automatic logic same_dest(input wb_item_t a, input wb_item_t b);
        return a.rd == b.rd;
    endfunction

endpackage

// File: rtl/wb_queue.sv
module wb_queue
    import rbwb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOTS-1:0]     in_valid,
    input  wb_item_t             in_item [SLOTS],
    output wb_item_t             head_item [WB_PORTS],
    output logic [WB_PORTS-1:0]  head_valid,
    output logic [CNT_W-1:0]     count
);

    wb_item_t           mem [DEPTH];
    logic [PTR_W-1:0]   head_ptr, tail_ptr;
    logic [CNT_W-1:0]   deq_n, enq_n, free_n;
    logic [SLOTS-1:0]   accept;
    logic [PTR_W-1:0]   pos [SLOTS];

    // Results leaving this edge: as many as ports allow.
    always_comb begin
        if (count >= CNT_W'(WB_PORTS)) deq_n = CNT_W'(WB_PORTS);
        else                           deq_n = count;
        free_n = CNT_W'(DEPTH) - count + deq_n;
    end

    // Rank valid slots oldest-first and place them behind the tail.
    always_comb begin
        logic [CNT_W-1:0] rank;
        rank = '0;
        for (int i = 0; i < SLOTS; i++) begin
            accept[i] = 1'b0;
            pos[i]    = tail_ptr + rank[PTR_W-1:0];
            if (in_valid[i] && (rank < free_n)) begin
                accept[i] = 1'b1;
                rank      = rank + 1'b1;
            end
        end
        enq_n = rank;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (accept[i]) mem[pos[i]] <= in_item[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            head_ptr <= head_ptr + deq_n[PTR_W-1:0];
            tail_ptr <= tail_ptr + enq_n[PTR_W-1:0];
            count    <= count - deq_n + enq_n;
        end
    end

    for (genvar p = 0; p < WB_PORTS; p++) begin : g_head
        assign head_item[p]  = mem[head_ptr + PTR_W'(p)];
        assign head_valid[p] = count > CNT_W'(p);
    end

endmodule

// File: rtl/wb_port_arb.sv
module wb_port_arb
    import rbwb_pkg::*;
(
    input  wb_item_t             head_item [WB_PORTS],
    input  logic [WB_PORTS-1:0]  head_valid,
    output logic [WB_PORTS-1:0]  wr_en,
    output areg_t                wr_reg  [WB_PORTS],
    output data_t                wr_data [WB_PORTS],
    output logic [WB_PORTS-1:0]  drain_valid,
    output tag_t                 drain_tag [WB_PORTS]
);

    logic collide;

    assign collide = head_valid[0] && head_valid[1]
                     && same_dest(head_item[0], head_item[1]);

    for (genvar p = 0; p < WB_PORTS; p++) begin : g_port
        assign wr_reg[p]      = head_item[p].rd;
        assign wr_data[p]     = head_item[p].data;
        assign drain_valid[p] = head_valid[p];
        assign drain_tag[p]   = head_item[p].tag;
    end

    // Older port yields to the younger one on a shared destination.
    assign wr_en[0] = head_valid[0] && !collide;
    assign wr_en[1] = head_valid[1];

endmodule

// File: rtl/wb_release.sv
module wb_release
    import rbwb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WB_PORTS-1:0]  drain_valid,
    input  tag_t                 drain_tag [WB_PORTS],
    output logic [WB_PORTS-1:0]  rel_valid,
    output tag_t                 rel_tag [WB_PORTS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_valid <= '0;
            for (int p = 0; p < WB_PORTS; p++) rel_tag[p] <= '0;
        end else begin
            rel_valid <= drain_valid;
            for (int p = 0; p < WB_PORTS; p++) rel_tag[p] <= drain_tag[p];
        end
    end

endmodule

// File: rtl/rb_writeback_sched.sv
module rb_writeback_sched
    import rbwb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [SLOTS-1:0]                    cmp_valid,
    input  logic [SLOTS-1:0][WB_TAG_W-1:0]      cmp_tag,
    input  logic [SLOTS-1:0][WB_REG_W-1:0]      cmp_reg,
    input  logic [SLOTS-1:0][WB_DATA_W-1:0]     cmp_data,
    output logic [WB_PORTS-1:0]                 wr_en,
    output logic [WB_PORTS-1:0][WB_REG_W-1:0]   wr_reg,
    output logic [WB_PORTS-1:0][WB_DATA_W-1:0]  wr_data,
    output logic [WB_PORTS-1:0]                 rel_valid,
    output logic [WB_PORTS-1:0][WB_TAG_W-1:0]   rel_tag,
    output logic [CNT_W-1:0]                    pend_count,
    output logic                                pend_full
);

    wb_item_t            in_item   [SLOTS];
    wb_item_t            head_item [WB_PORTS];
    logic [WB_PORTS-1:0] head_valid;
    areg_t               arb_reg   [WB_PORTS];
    data_t               arb_data  [WB_PORTS];
    logic [WB_PORTS-1:0] drain_valid;
    tag_t                drain_tag [WB_PORTS];
    tag_t                rel_tag_u [WB_PORTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_in
        assign in_item[i] = '{tag: cmp_tag[i], rd: cmp_reg[i], data: cmp_data[i]};
    end

    wb_queue #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (cmp_valid),
        .in_item    (in_item),
        .head_item  (head_item),
        .head_valid (head_valid),
        .count      (pend_count)
    );

    wb_port_arb u_arb (
        .head_item   (head_item),
        .head_valid  (head_valid),
        .wr_en       (wr_en),
        .wr_reg      (arb_reg),
        .wr_data     (arb_data),
        .drain_valid (drain_valid),
        .drain_tag   (drain_tag)
    );

    wb_release u_rel (
        .clk         (clk),
        .rst         (rst),
        .drain_valid (drain_valid),
        .drain_tag   (drain_tag),
        .rel_valid   (rel_valid),
        .rel_tag     (rel_tag_u)
    );

    for (genvar p = 0; p < WB_PORTS; p++) begin : g_out
        assign wr_reg[p]  = arb_reg[p];
        assign wr_data[p] = arb_data[p];
        assign rel_tag[p] = rel_tag_u[p];
    end

    assign pend_full = pend_count == CNT_W'(DEPTH);

endmodule

// File: rtl/rbwb_checker.sv
module rbwb_checker
    import rbwb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                               clk,
    input logic                               rst,
    input logic [WB_PORTS-1:0]                wr_en,
    input logic [WB_PORTS-1:0][WB_REG_W-1:0]  wr_reg,
    input logic [WB_PORTS-1:0]                rel_valid,
    input logic [CNT_W-1:0]                   pend_count,
    input logic                               pend_full
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pend_count == 0 && !pend_full && wr_en == 2'b00 && rel_valid == 2'b00));

    p_port1_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_count < 2) |-> !wr_en[1]);

    p_drain_active_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_count != 0) |-> (wr_en != 2'b00));

    p_distinct_dest_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 2'b11) |-> (wr_reg[0] != wr_reg[1]));

    p_young_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_count >= 2) |-> wr_en[1]);

    p_release_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_count >= 2) |=> (rel_valid == 2'b11));

    p_release_one_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_count == 1) |=> (rel_valid == 2'b01));

    p_release_none_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_count == 0) |=> (rel_valid == 2'b00));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(pend_count) <= int'($past(pend_count)) + SLOTS
                  && int'(pend_count) + WB_PORTS >= int'($past(pend_count))));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        int'(pend_count) <= DEPTH);

endmodule

bind rb_writeback_sched rbwb_checker #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_reg     (wr_reg),
    .rel_valid  (rel_valid),
    .pend_count (pend_count),
    .pend_full  (pend_full)
);

// File: tb/sim_rb_writeback_sched.sv
`timescale 1ns/1ps
module sim_rb_writeback_sched;
    import rbwb_pkg::*;

    localparam int DEPTH = 8;
    localparam int SLOTS = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                              clk = 1'b0;
    logic                              rst = 1'b1;
    logic [SLOTS-1:0]                  cmp_valid = '0;
    logic [SLOTS-1:0][WB_TAG_W-1:0]    cmp_tag = '0;
    logic [SLOTS-1:0][WB_REG_W-1:0]    cmp_reg = '0;
    logic [SLOTS-1:0][WB_DATA_W-1:0]   cmp_data = '0;
    logic [1:0]                        wr_en;
    logic [1:0][WB_REG_W-1:0]          wr_reg;
    logic [1:0][WB_DATA_W-1:0]         wr_data;
    logic [1:0]                        rel_valid;
    logic [1:0][WB_TAG_W-1:0]          rel_tag;
    logic [CNT_W-1:0]                  pend_count;
    logic                              pend_full;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    rb_writeback_sched #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u0 (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .cmp_reg(cmp_reg), .cmp_data(cmp_data), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_data(wr_data), .rel_valid(rel_valid), .rel_tag(rel_tag),
        .pend_count(pend_count), .pend_full(pend_full)
    );

    typedef struct packed {
        logic [3:0]      mask;
        logic [3:0][4:0] rg;
        logic [1:0]      exp_en;
        logic [1:0]      s0;
        logic [1:0]      s1;
        logic [3:0]      exp_cnt;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{mask: 4'b0011, rg: {5'd0,  5'd0,  5'd2,  5'd1},  exp_en: 2'b11, s0: 2'd0, s1: 2'd1, exp_cnt: 4'd2}, // R2 R3
        '{mask: 4'b1010, rg: {5'd4,  5'd0,  5'd3,  5'd0},  exp_en: 2'b11, s0: 2'd1, s1: 2'd3, exp_cnt: 4'd2}, // R2 sparse
        '{mask: 4'b0001, rg: {5'd0,  5'd0,  5'd0,  5'd7},  exp_en: 2'b01, s0: 2'd0, s1: 2'd0, exp_cnt: 4'd1}, // R3 one
        '{mask: 4'b0011, rg: {5'd0,  5'd0,  5'd5,  5'd5},  exp_en: 2'b10, s0: 2'd0, s1: 2'd1, exp_cnt: 4'd2}, // R4
        '{mask: 4'b1111, rg: {5'd12, 5'd11, 5'd10, 5'd9},  exp_en: 2'b11, s0: 2'd0, s1: 2'd1, exp_cnt: 4'd4}, // R2 R6
        '{mask: 4'b1000, rg: {5'd31, 5'd0,  5'd0,  5'd0},  exp_en: 2'b01, s0: 2'd3, s1: 2'd0, exp_cnt: 4'd1}  // R2 top slot
    };

    function automatic logic [WB_TAG_W-1:0] mk_tag(input int v, input int i);
        return WB_TAG_W'(((v & 3) << 2) | (i & 3));
    endfunction

    function automatic logic [WB_DATA_W-1:0] mk_data(input int v, input int i);
        return 32'hC0DE_0000 | WB_DATA_W'(v << 4) | WB_DATA_W'(i);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_slots(input logic [3:0] mask, input logic [3:0][4:0] rg, input int v);
        for (int i = 0; i < SLOTS; i++) begin
            cmp_tag[i]  = mk_tag(v, i);
            cmp_reg[i]  = rg[i];
            cmp_data[i] = mk_data(v, i);
        end
        cmp_valid = mask;
    endtask

    task automatic push_seq(input int base);
        logic [3:0][4:0] rg;
        for (int i = 0; i < SLOTS; i++) rg[i] = 5'(base + i);
        drive_slots(4'b1111, rg, base);
    endtask

    initial begin : watchdog
        #(100000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", 64'(pend_count), 64'd0);
        check("R1 full", 64'(pend_full), 64'd0);
        check("R1 wr_en", 64'(wr_en), 64'd0);
        check("R1 rel", 64'(rel_valid), 64'd0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            drive_slots(VEC[v].mask, VEC[v].rg, v);
            @(negedge clk);
            cmp_valid = '0;
            check("R6 count", 64'(pend_count), 64'(VEC[v].exp_cnt));
            check("R3 R4 wr_en", 64'(wr_en), 64'(VEC[v].exp_en));
            if (VEC[v].exp_en[0]) begin
                check("R2 R3 port0 reg", 64'(wr_reg[0]), 64'(VEC[v].rg[VEC[v].s0]));
                check("R2 port0 data", 64'(wr_data[0]), 64'(mk_data(v, int'(VEC[v].s0))));
            end
            if (VEC[v].exp_en[1]) begin
                check("R3 R4 port1 reg", 64'(wr_reg[1]), 64'(VEC[v].rg[VEC[v].s1]));
                check("R4 port1 data", 64'(wr_data[1]), 64'(mk_data(v, int'(VEC[v].s1))));
            end
            @(negedge clk);
            check("R5 rel_valid", 64'(rel_valid), (VEC[v].exp_cnt >= 2) ? 64'd3 : 64'd1);
            check("R5 rel_tag0", 64'(rel_tag[0]), 64'(mk_tag(v, int'(VEC[v].s0))));
            if (VEC[v].exp_cnt >= 2)
                check("R5 rel_tag1", 64'(rel_tag[1]), 64'(mk_tag(v, int'(VEC[v].s1))));
            repeat (3) @(negedge clk);
            check("R6 drained", 64'(pend_count), 64'd0);
        end

        // R7 R8: fill while draining, overflow drops youngest
        push_seq(1);
        @(negedge clk);
        check("R8 count after first", 64'(pend_count), 64'd4);
        check("R3 order a", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd2, 5'd1}));
        push_seq(5);
        @(negedge clk);
        check("R8 accept while drain", 64'(pend_count), 64'd6);
        check("R3 order b", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd4, 5'd3}));
        push_seq(9);
        @(negedge clk);
        check("R6 full count", 64'(pend_count), 64'd8);
        check("R6 full flag", 64'(pend_full), 64'd1);
        check("R3 order c", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd6, 5'd5}));
        push_seq(13);
        @(negedge clk);
        cmp_valid = '0;
        check("R7 count capped", 64'(pend_count), 64'd8);
        check("R7 full held", 64'(pend_full), 64'd1);
        check("R3 order d", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd8, 5'd7}));
        @(negedge clk);
        check("R6 count e", 64'(pend_count), 64'd6);
        check("R6 not full", 64'(pend_full), 64'd0);
        check("R3 order e", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd10, 5'd9}));
        @(negedge clk);
        check("R3 order f", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd12, 5'd11}));
        @(negedge clk);
        check("R7 kept oldest", 64'({wr_reg[1], wr_reg[0]}), 64'({5'd14, 5'd13}));
        check("R7 count g", 64'(pend_count), 64'd2);
        @(negedge clk);
        check("R7 youngest dropped", 64'(pend_count), 64'd0);
        check("R7 ports idle", 64'(wr_en), 64'd0);

        // R1: reset with results pending
        push_seq(20);
        @(negedge clk);
        cmp_valid = '0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid count", 64'(pend_count), 64'd0);
        check("R1 mid wr_en", 64'(wr_en), 64'd0);
        check("R1 mid rel", 64'(rel_valid), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule